// File: doc/BRIEF.md
# Stereo Compare-Connect Matcher

After playback has been interrupted and the source is read again, this block finds the point in the re-read stereo stream that lines up with the last samples already stored. Recording can then resume without a gap or a repeat. While the block is idle it keeps a reference window of the six most recent words (three left/right pairs). A start command freezes that window. From then on the block compares the incoming stream against it, and it emits a one-clock connect pulse when alignment is found. Encoding restarts on that pulse.

There are three search modes. The strict mode needs all three pairs to match. The tolerant mode accepts any two of the three pairs. The direct mode does no comparison and connects after three words. A live flag can drop the four least significant bits of every word from the comparison. The first start after reset waits for a preparation interval before any sample counts. A later start skips that wait.

Top module: `stereo_splice_matcher`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `connect` and `enc_on` are low, and the next start is treated as the first one.
- R2: While `busy` is low, every sample strobe with no command in the same cycle shifts `smp_data` into the reference window, so the window holds the last six such words. While `busy` is high, the reference window does not change.
- R3: A command with `cmd_mode` = 2'b11 (three-pair), 2'b10 (two-pair) or 2'b01 (direct) is a start. In the following cycle `busy` is high and the word count is cleared. A sample presented in the same cycle as any command is ignored.
- R4: The first start after reset opens a preparation interval of PREP_CYCLES clocks, and samples strobed during it are ignored. A start issued after that does not reload the interval.
- R5: Comparison begins with the first left word (`smp_right` = 0) accepted after preparation. Right words that arrive before it are dropped.
- R6: In three-pair mode, a connect occurs on an accepted right word when at least six words have been taken and the six newest words equal the reference words position by position.
- R7: In two-pair mode, the window is the same, but two of the three pairs matching is enough. A pair matches only when both its left word and its right word match.
- R8: In direct mode, the connect occurs on the third accepted word, with no comparison.
- R9: While `cmp12` is high, bits [3:0] are excluded from every comparison. The flag is read at each evaluation, so a change applies from the next evaluation onward.
- R10: `connect` is high for exactly one clock, in the cycle after the completing word. `busy` falls on the same edge.
- R11: A command with `cmd_mode` = 2'b00 (stop) clears `busy` without a connect. Issued while idle, it leaves `busy` low.
- R12: `enc_on` rises with a connect. A start clears it, even when `cmd_enc` is set in the same command. Any other command loads `cmd_enc` into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Sample strobe |
| smp_right | input | 1 | Channel of the sample: 0 left, 1 right |
| smp_data | input | W | Sample word |
| cmd_vld | input | 1 | Command strobe |
| cmd_mode | input | 2 | 11 three-pair, 10 two-pair, 01 direct, 00 stop |
| cmd_enc | input | 1 | Encode-enable bit carried with the command |
| cmp12 | input | 1 | Exclude bits [3:0] from the comparison |
| busy | output | 1 | Search in progress |
| connect | output | 1 | One-clock alignment pulse |
| enc_on | output | 1 | Encode running |

## Verification
The hardest case to reach from the ports is a two-pair connect in which the failing pair differs in only one of its two words. The stream must also be aligned to a left word, and the first-start preparation must already be over. Directed sequences first load a known reference. They then replay it with one word corrupted, or with one word corrupted in each of two different pairs, and add low-nibble noise with the 12-bit flag toggled. After that, seeded random traffic from a two-value palette gives frequent accidental partial matches, misaligned right words and commands that collide with samples.

// File: rtl/splice_pkg.sv
// Shared types of the stereo compare-connect matcher.
package splice_pkg;
    typedef enum logic [1:0] {
        CC_STOP   = 2'b00,
        CC_DIRECT = 2'b01,
        CC_TWO    = 2'b10,
        CC_THREE  = 2'b11
    } cc_mode_e;
endpackage

// File: rtl/splice_window.sv
// Word shift register, newest word at index 0.
// Assumes: shift is a single-cycle strobe qualified by the caller.
module splice_window #(
    parameter int W     = 16,
    parameter int DEPTH = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      shift,
    input  logic [W-1:0]              din,
    output logic [DEPTH-1:0][W-1:0]   q
);
    // Push one word in and age the rest by one slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (shift) begin
            q[0] <= din;
            for (int i = 1; i < DEPTH; i++) begin
                q[i] <= q[i-1];
            end
        end
    end
endmodule

// File: rtl/splice_pair_cmp.sv
// Compares a candidate window with the reference window pair by pair,
// with an optional mask on the low bits. Purely combinational.
// Assumes: a pair occupies slots 2k (right) and 2k+1 (left).
module splice_pair_cmp #(
    parameter int W     = 16,
    parameter int PAIRS = 3,
    parameter int IGN   = 4,
    localparam int WORDS = 2 * PAIRS,
    localparam int HW    = $clog2(PAIRS + 1)
) (
    input  logic [WORDS-1:0][W-1:0] cand,
    input  logic [WORDS-1:0][W-1:0] refw,
    input  logic                    mask_lsb,
    output logic [PAIRS-1:0]        pair_eq,
    output logic [HW-1:0]           eq_cnt
);
    logic [W-1:0] mask;

    // Select the full-width or the truncated compare mask.
    always_comb mask = mask_lsb ? {{(W-IGN){1'b1}}, {IGN{1'b0}}} : {W{1'b1}};

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        logic r_ok, l_ok;
        assign r_ok = ((cand[2*k]   ^ refw[2*k])   & mask) == '0;
        assign l_ok = ((cand[2*k+1] ^ refw[2*k+1]) & mask) == '0;
        assign pair_eq[k] = r_ok && l_ok;
    end

    // Count the matching pairs.
    always_comb begin
        eq_cnt = '0;
        for (int k = 0; k < PAIRS; k++) begin
            eq_cnt = eq_cnt + HW'(pair_eq[k]);
        end
    end
endmodule

// File: rtl/stereo_splice_matcher.sv
// Compare-connect matcher: freezes the last stored stereo words on start,
// searches the re-read stream for them and pulses connect when aligned.
// Assumes: the stream alternates left/right once aligned; commands and
// samples are single-cycle strobes; a command cycle drops its sample.
module stereo_splice_matcher
    import splice_pkg::*;
#(
    parameter int W           = 16,
    parameter int PAIRS       = 3,
    parameter int IGN_LSB     = 4,
    parameter int PREP_CYCLES = 40,
    parameter int DIR_WORDS   = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_vld,
    input  logic         smp_right,
    input  logic [W-1:0] smp_data,
    input  logic         cmd_vld,
    input  logic [1:0]   cmd_mode,
    input  logic         cmd_enc,
    input  logic         cmp12,
    output logic         busy,
    output logic         connect,
    output logic         enc_on
);
    localparam int WORDS = 2 * PAIRS;
    localparam int CW    = $clog2(WORDS + 1);
    localparam int PW    = $clog2(PREP_CYCLES + 1);
    localparam int HW    = $clog2(PAIRS + 1);

    logic                    is_start, is_stop, take_ref, can_cmp;
    logic                    pair_hit, dir_hit, hit;
    logic                    primed, aligned;
    logic [PW-1:0]           prep_cnt;
    logic [CW-1:0]           word_cnt;
    cc_mode_e                mode_q;
    logic [WORDS-1:0][W-1:0] ref_q, win_q, cand;
    logic [PAIRS-1:0]        pair_eq;
    logic [HW-1:0]           eq_cnt, need;

    // Decode the command and qualify the sample.
    always_comb begin
        is_start = cmd_vld && (cc_mode_e'(cmd_mode) != CC_STOP);
        is_stop  = cmd_vld && (cc_mode_e'(cmd_mode) == CC_STOP);
        take_ref = smp_vld && !cmd_vld && !busy;
        can_cmp  = smp_vld && !cmd_vld && busy && (prep_cnt == '0)
                   && (aligned || !smp_right);
    end

    // Reference window, filled only while idle.
    splice_window #(.W(W), .DEPTH(WORDS)) u_ref (
        .clk(clk), .rst_n(rst_n), .shift(take_ref), .din(smp_data), .q(ref_q)
    );

    // Incoming window, filled by accepted search words.
    splice_window #(.W(W), .DEPTH(WORDS)) u_win (
        .clk(clk), .rst_n(rst_n), .shift(can_cmp), .din(smp_data), .q(win_q)
    );

    // Candidate = incoming window as it stands after this word.
    assign cand[0] = smp_data;
    for (genvar i = 1; i < WORDS; i++) begin : g_cand
        assign cand[i] = win_q[i-1];
    end

    splice_pair_cmp #(.W(W), .PAIRS(PAIRS), .IGN(IGN_LSB)) u_cmp (
        .cand(cand), .refw(ref_q), .mask_lsb(cmp12),
        .pair_eq(pair_eq), .eq_cnt(eq_cnt)
    );

    // Decide whether this word completes an alignment.
    always_comb begin
        need     = (mode_q == CC_THREE) ? HW'(PAIRS) : HW'(PAIRS - 1);
        pair_hit = can_cmp && smp_right && (mode_q != CC_DIRECT)
                   && (word_cnt >= CW'(WORDS - 1)) && (eq_cnt >= need);
        dir_hit  = can_cmp && (mode_q == CC_DIRECT)
                   && (word_cnt == CW'(DIR_WORDS - 1));
        hit      = pair_hit || dir_hit;
    end

    // Search state: busy flag and latched mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            mode_q <= CC_STOP;
        end else if (is_start) begin
            busy   <= 1'b1;
            mode_q <= cc_mode_e'(cmd_mode);
        end else if (is_stop || hit) begin
            busy   <= 1'b0;
        end
    end

    // Preparation interval, loaded only by the first start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed   <= 1'b0;
            prep_cnt <= '0;
        end else if (is_start && !primed) begin
            primed   <= 1'b1;
            prep_cnt <= PW'(PREP_CYCLES);
        end else if (prep_cnt != '0) begin
            prep_cnt <= prep_cnt - 1'b1;
        end
    end

    // Left-word alignment and saturating count of accepted words.
    always_ff @(posedge clk) begin
        if (!rst_n || is_start) begin
            aligned  <= 1'b0;
            word_cnt <= '0;
        end else if (can_cmp) begin
            aligned <= 1'b1;
            if (word_cnt != CW'(WORDS)) word_cnt <= word_cnt + 1'b1;
        end
    end

    // Connect pulse and encode-run flag; a start outranks the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            connect <= 1'b0;
            enc_on  <= 1'b0;
        end else begin
            connect <= hit;
            if (is_start)     enc_on <= 1'b0;
            else if (cmd_vld) enc_on <= cmd_enc;
            else if (hit)     enc_on <= 1'b1;
        end
    end
endmodule

// File: rtl/stereo_splice_matcher_chk.sv
// Port-level properties of the matcher, bound to every instance.
module stereo_splice_matcher_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       smp_vld,
    input logic       cmd_vld,
    input logic [1:0] cmd_mode,
    input logic       busy,
    input logic       connect,
    input logic       enc_on
);
    a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        connect |=> !connect);
    a_r10_busy_falls: assert property (@(posedge clk) disable iff (!rst_n)
        connect |-> (!busy && $past(busy)));
    a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_mode != 2'b00) |=> (busy && !connect));
    a_r11_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_mode == 2'b00) |=> (!busy && !connect));
    a_r12_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_mode != 2'b00) |=> !enc_on);
    a_r12_connect_runs: assert property (@(posedge clk) disable iff (!rst_n)
        connect |-> enc_on);
    a_r2_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmd_vld && !smp_vld) |=> busy);
endmodule

bind stereo_splice_matcher stereo_splice_matcher_chk u_chk (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .cmd_vld(cmd_vld),
    .cmd_mode(cmd_mode), .busy(busy), .connect(connect), .enc_on(enc_on)
);

// File: tb/stereo_splice_matcher_tb.sv
// Self-checking bench: cycle model built from the requirements, directed
// corner cases, then seeded random traffic.
module stereo_splice_matcher_tb;
    localparam int PREP = 40;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        smp_vld = 0, smp_right = 0, cmd_vld = 0, cmd_enc = 0, cmp12 = 0;
    logic [15:0] smp_data = '0;
    logic [1:0]  cmd_mode = '0;
    logic        busy, connect, enc_on;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Reference model state.
    logic [15:0] m_ref [6];
    logic [15:0] m_win [6];
    bit m_busy, m_primed, m_al, m_enc;
    int m_prep, m_cnt;
    logic [1:0] m_mode;

    always #5 clk = ~clk;

    stereo_splice_matcher #(.PREP_CYCLES(PREP)) u_dut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_right(smp_right),
        .smp_data(smp_data), .cmd_vld(cmd_vld), .cmd_mode(cmd_mode),
        .cmd_enc(cmd_enc), .cmp12(cmp12), .busy(busy), .connect(connect),
        .enc_on(enc_on)
    );

    function automatic bit weq(input logic [15:0] a, input logic [15:0] b, input bit m12);
        return m12 ? (a[15:4] == b[15:4]) : (a == b);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 6; i++) begin m_ref[i] = '0; m_win[i] = '0; end
        m_busy = 0; m_primed = 0; m_al = 0; m_enc = 0; m_prep = 0; m_cnt = 0; m_mode = 0;
    endtask

    task automatic report(input bit ok, input string tag, input string what,
                          input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One clock: drive at a falling edge, predict, compare at the next one.
    task automatic cyc(input bit cv, input logic [1:0] md, input bit ce,
                       input bit sv, input logic [15:0] d, input bit r, input string tag);
        bit hit, start, stop;
        logic [15:0] cand [6];
        int eq;
        cmd_vld = cv; cmd_mode = md; cmd_enc = ce;
        smp_vld = sv; smp_data = d; smp_right = r;
        hit = 0; start = cv && md != 2'b00; stop = cv && md == 2'b00;
        if (!cv && sv) begin
            if (!m_busy) begin
                for (int i = 5; i > 0; i--) m_ref[i] = m_ref[i-1];
                m_ref[0] = d;
            end else if (m_prep == 0 && (m_al || !r)) begin
                cand[0] = d;
                for (int i = 1; i < 6; i++) cand[i] = m_win[i-1];
                eq = 0;
                for (int k = 0; k < 3; k++)
                    if (weq(cand[2*k], m_ref[2*k], cmp12) && weq(cand[2*k+1], m_ref[2*k+1], cmp12)) eq++;
                if (m_mode == 2'b01) hit = (m_cnt == 2);
                else hit = r && m_cnt >= 5 && eq >= ((m_mode == 2'b11) ? 3 : 2);
                for (int i = 0; i < 6; i++) m_win[i] = cand[i];
                m_al = 1;
                if (m_cnt < 6) m_cnt++;
            end
        end
        if (start && !m_primed) begin m_primed = 1; m_prep = PREP; end
        else if (m_prep > 0) m_prep--;
        if (start) begin m_busy = 1; m_mode = md; m_cnt = 0; m_al = 0; m_enc = 0; end
        else if (stop) begin m_busy = 0; m_enc = ce; end
        else if (hit) begin m_busy = 0; m_enc = 1; end
        @(negedge clk);
        report(connect === hit, tag, "connect", connect, hit);
        report(busy === m_busy, tag, "busy", busy, m_busy);
        report(enc_on === m_enc, tag, "enc_on", enc_on, m_enc);
        cmd_vld = 0; smp_vld = 0;
    endtask

    task automatic smp(input logic [15:0] d, input bit r, input string tag);
        cyc(0, 2'b00, 0, 1, d, r, tag);
    endtask
    task automatic cmd(input logic [1:0] md, input bit ce, input string tag);
        cyc(1, md, ce, 0, '0, 0, tag);
    endtask
    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 2'b00, 0, 0, '0, 0, tag);
    endtask
    // Send three pairs L0 R0 L1 R1 L2 R2 taken from base+offset.
    task automatic pairs(input logic [15:0] base, input logic [15:0] x0,
                         input logic [15:0] x3, input string tag);
        for (int i = 0; i < 6; i++)
            smp(base + 16'(i * 16'h0110) ^ (i == 0 ? x0 : 16'h0) ^ (i == 3 ? x3 : 16'h0),
                bit'(i % 2), tag);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int p;
        bit lr;
        logic [15:0] w;
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        idle(2, "R1");
        // R11: stop while idle keeps busy low
        cmd(2'b00, 0, "R11");
        // R2: load reference while idle
        pairs(16'h1000, 0, 0, "R2");
        // R4: first start, matching words during preparation are ignored
        cmd(2'b11, 0, "R4");
        pairs(16'h1000, 0, 0, "R4");
        idle(PREP, "R4");
        // R5: stray right word dropped, then R6 exact replay connects
        smp(16'h7777, 1, "R5");
        pairs(16'h1000, 0, 0, "R6");
        // R10: no second pulse
        idle(2, "R10");
        // R12 + R4: start with enable bit set still clears enc_on, no new prep
        pairs(16'h2000, 0, 0, "R2");
        cmd(2'b10, 1, "R12");
        // R7: one corrupted word in pair 0 still connects in two-pair mode
        pairs(16'h2000, 16'h0100, 0, "R7");
        // R7: corrupt one word in each of two pairs: no connect, then R11 stop
        pairs(16'h3000, 0, 0, "R2");
        cmd(2'b10, 0, "R7");
        pairs(16'h3000, 16'h0100, 16'h0200, "R7");
        cmd(2'b00, 1, "R11");
        // R9: low-nibble differences block, then cmp12 lets them match
        pairs(16'h4000, 0, 0, "R2");
        cmd(2'b11, 0, "R9");
        pairs(16'h4000, 16'h0005, 16'h000A, "R9");
        cmp12 = 1;
        pairs(16'h4000, 16'h0005, 16'h000A, "R9");
        cmp12 = 0;
        // R8: direct mode connects on third word
        cmd(2'b01, 0, "R8");
        smp(16'h1234, 0, "R8"); smp(16'h5678, 1, "R8"); smp(16'h9ABC, 0, "R8");
        idle(1, "R8");
        // R3: sample in a command cycle is ignored
        cyc(1, 2'b11, 0, 1, 16'h0, 0, "R3");
        // Random traffic
        lr = 0;
        for (int n = 0; n < 4000; n++) begin
            p = int'($urandom % 100);
            if (p < 3) cmd(2'(1 + $urandom % 3), bit'($urandom % 2), "R3");
            else if (p < 5) cmd(2'b00, bit'($urandom % 2), "R11");
            else if (p < 8) begin cmp12 = ~cmp12; idle(1, "R9"); end
            else if (p < 85) begin
                w = ($urandom % 2) ? 16'hA5A0 : 16'h3C30;
                if ($urandom % 5 == 0) w[3:0] = 4'($urandom);
                if ($urandom % 20 == 0) lr = ~lr;
                smp(w, lr, "R6");
                lr = ~lr;
            end else idle(1, "R2");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule